// File: doc/BRIEF.md
# Serial ADC Port Device Emulator

This block stands in for a 12-bit serial sampling converter on a board or in a chip-level environment where the real converter is absent. A local source supplies the sample word. The block answers a host's convert strobe, shift clock and configuration input in the same way the converter would. The convert strobe's rising edge starts a conversion of fixed length. When the strobe falls, the data output driver turns on and the result leaves most significant bit first, one bit per falling shift-clock edge. Once the word has gone out, only zeros follow.

All three host lines are asynchronous to the system clock. Each passes through a synchronizer, and edges are found on the synchronized copies. The shift clock must therefore run well below the system clock. During the first two rising shift-clock edges of a transfer, the block captures a two-bit input-selection word. That word takes effect at the next conversion start, and the block reports the positive and negative inputs it chose for each conversion. The data output has a separate enable, so a pad or a shared line can be tri-stated outside the transfer window.

Top module: `adc_port_emu`

## Requirements
- R1: A synchronized rising edge on `conv_i`, seen outside a conversion, starts a conversion. `state_o` reads 1 for exactly CONV_CYCLES system clocks. State codes: 0 idle, 1 converting, 2 sleeping, 3 transferring, 4 trailing zeros.
- R2: If `conv_i` is still high when the conversion ends, the block goes to sleep (code 2). `sdo_oe_o` stays low whenever `conv_i` has been high for two synchronized cycles.
- R3: A falling `conv_i` during sleep, or a conversion that ends with `conv_i` already low, enters transfer (code 3). `sdo_oe_o` then goes high and `sdo_o` shows bit 11 of the result.
- R4: Each synchronized falling `sck_i` edge in transfer moves `sdo_o` to the next lower bit, so bits 10 down to 0 appear after falls 1 to 11.
- R5: From the 12th falling edge on, the block holds code 4, `sdo_oe_o` stays high and `sdo_o` is 0 for any number of further `sck_i` edges, as long as `conv_i` stays low.
- R6: `sdi_i` is sampled on the first two rising `sck_i` edges of a transfer, the first as SGL and the second as ODD. Later rising edges in that transfer are ignored. A transfer with fewer than two rising edges leaves the stored word unchanged.
- R7: Input-pair decode: SGL=1 selects channel ODD against ground (`neg_gnd_o`=1, `neg_ch_o`=0). SGL=0 selects channel ODD as positive and channel !ODD as negative (`neg_gnd_o`=0). `pos_ch_o` always equals ODD.
- R8: The pair outputs change only when a conversion starts, and they then take the last complete stored word.
- R9: A rising `conv_i` during transfer or trailing zeros aborts the frame and starts a new conversion. A rising `conv_i` during a conversion is ignored and does not lengthen it.
- R10: After reset the state is idle (0), `sdo_oe_o` and `sdo_o` are 0, and the pair is channel 0 against ground (SGL=1, ODD=0).
- R11: `sample_i` is captured on the last conversion cycle. Changes after that do not alter the transmitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_i | input | 1 | Convert strobe from the host (asynchronous) |
| sck_i | input | 1 | Shift clock from the host (asynchronous) |
| sdi_i | input | 1 | Configuration data from the host (asynchronous) |
| sample_i | input | DATA_W | Sample word from the local source |
| sdo_o | output | 1 | Serial result bit |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (1 drives the line) |
| pos_ch_o | output | 1 | Positive input channel of the current conversion |
| neg_ch_o | output | 1 | Negative input channel when not grounded |
| neg_gnd_o | output | 1 | 1 when the negative input is ground |
| state_o | output | 3 | Port state code (see R1) |

## Verification
The end of a conversion and a falling convert strobe can occur in the same system cycle. The block settles this on the strobe level rather than on the edge pulse. The bench provokes the case by lowering the strobe in the middle of a conversion, after a second rising edge that must not restart it. It then samples the state one cycle after the original conversion should have ended, where transfer with bit 11 on the data line is the only correct outcome. A second overlap, a frame abort arriving while shift-clock edges are still pending, is judged by the output enable dropping and the state reading converting.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_XFER  = 3'd3,
    ST_TAIL  = 3'd4
  } emu_state_e;

  typedef struct packed {
    logic sgl;
    logic odd;
  } mux_word_t;

  localparam mux_word_t MUX_RESET = '{sgl: 1'b1, odd: 1'b0};

endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/adc_emu_shift.sv
module adc_emu_shift #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              step_i,
  output logic              bit_o,
  output logic              last_o
);

  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);
  localparam logic [CW-1:0] LASTB = CW'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              sh_en;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    sh_en = load_i | step_i;
    if (load_i) begin
      sh_d  = data_i;
      cnt_d = '0;
    end else if (step_i) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
      if (cnt_q != FULL) begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o  = sh_q[DATA_W-1];
  assign last_o = (cnt_q == LASTB);

  // R5: once every bit has left, only zeros remain in the register
  p_drained_zero_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL) |-> (sh_q == '0));

  // R4: bit counter never passes the word length
  p_count_bound_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);

  // R4: the word moves only on a load or a shift-clock step
  p_hold_without_step_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(sh_q));

endmodule

// File: rtl/adc_emu_cfg.sv
module adc_emu_cfg
  import adc_emu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic sck_rise_i,
  input  logic sdi_i,
  input  logic apply_i,
  output logic pos_ch_o,
  output logic neg_ch_o,
  output logic neg_gnd_o
);

  logic [1:0] rcnt_q, rcnt_d;
  logic       first_q, first_d;
  mux_word_t  pend_q, pend_d;
  mux_word_t  act_q, act_d;

  always_comb begin
    rcnt_d  = rcnt_q;
    first_d = first_q;
    pend_d  = pend_q;
    act_d   = act_q;
    if (frame_start_i) begin
      rcnt_d = 2'd0;
    end else if (sck_rise_i && (rcnt_q != 2'd2)) begin
      rcnt_d = rcnt_q + 2'd1;
      if (rcnt_q == 2'd0) begin
        first_d = sdi_i;
      end else begin
        pend_d = '{sgl: first_q, odd: sdi_i};
      end
    end
    if (apply_i) begin
      act_d = pend_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q  <= 2'd2;
      first_q <= 1'b0;
      pend_q  <= MUX_RESET;
      act_q   <= MUX_RESET;
    end else begin
      rcnt_q  <= rcnt_d;
      first_q <= first_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
    end
  end

  always_comb begin
    pos_ch_o  = act_q.odd;
    neg_gnd_o = act_q.sgl;
    neg_ch_o  = act_q.sgl ? 1'b0 : ~act_q.odd;
  end

  // R6: after two captured bits the stored word ignores further SDI
  p_late_sdi_ignored_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rcnt_q == 2'd2) && !frame_start_i) |=> $stable(pend_q));

  // R8: the applied pair moves only at a conversion start
  p_pair_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(act_q));

  // R7: a differential pair never uses the same channel twice
  p_pair_distinct_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_gnd_o |-> (pos_ch_o != neg_ch_o));

endmodule

// File: rtl/adc_port_emu.sv
module adc_port_emu
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              pos_ch_o,
  output logic              neg_ch_o,
  output logic              neg_gnd_o,
  output logic [2:0]        state_o
);

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam int PIN_CONV = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDI  = 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  // pin synchronizers and edge finders
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  adc_emu_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i ({sdi_i, sck_i, conv_i}),
    .lvl_o   (pin_lvl),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  logic conv_lvl, conv_rise, conv_fall, sck_rise, sck_fall, sdi_lvl;
  logic unused_sdi_edges;
  assign conv_lvl  = pin_lvl[PIN_CONV];
  assign conv_rise = pin_rise[PIN_CONV];
  assign conv_fall = pin_fall[PIN_CONV];
  assign sck_rise  = pin_rise[PIN_SCK];
  assign sck_fall  = pin_fall[PIN_SCK];
  assign sdi_lvl   = pin_lvl[PIN_SDI];
  assign unused_sdi_edges = pin_rise[PIN_SDI] ^ pin_fall[PIN_SDI];

  // state, conversion timer and result
  emu_state_e        state_q, state_d;
  logic [CNT_W-1:0]  conv_cnt_q, conv_cnt_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              start, conv_end, load, step, cfg_rise, in_frame;
  logic              shift_bit, shift_last;
  logic [DATA_W-1:0] load_data;

  always_comb begin
    in_frame  = (state_q == ST_XFER) || (state_q == ST_TAIL);
    start     = conv_rise && (state_q != ST_CONV);
    conv_end  = (state_q == ST_CONV) && (conv_cnt_q == CONV_LAST);
    load      = (conv_end && !conv_lvl) ||
                ((state_q == ST_SLEEP) && conv_fall && !start);
    load_data = conv_end ? sample_i : res_q;
    step      = sck_fall && (state_q == ST_XFER) && !start;
    cfg_rise  = sck_rise && in_frame;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (conv_end) state_d = conv_lvl ? ST_SLEEP : ST_XFER;
      end
      ST_SLEEP: begin
        if (start)          state_d = ST_CONV;
        else if (conv_fall) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (start)                      state_d = ST_CONV;
        else if (step && shift_last)    state_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (start) state_d = ST_CONV;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    conv_cnt_d = conv_cnt_q;
    if (start) begin
      conv_cnt_d = '0;
    end else if ((state_q == ST_CONV) && !conv_end) begin
      conv_cnt_d = conv_cnt_q + CNT_W'(1);
    end
    res_d = conv_end ? sample_i : res_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      conv_cnt_q <= '0;
      res_q      <= '0;
    end else begin
      state_q    <= state_d;
      conv_cnt_q <= conv_cnt_d;
      if (conv_end) begin
        res_q <= res_d;
      end
    end
  end

  adc_emu_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (load),
    .data_i (load_data),
    .step_i (step),
    .bit_o  (shift_bit),
    .last_o (shift_last)
  );

  adc_emu_cfg u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .frame_start_i (load),
    .sck_rise_i    (cfg_rise),
    .sdi_i         (sdi_lvl),
    .apply_i       (start),
    .pos_ch_o      (pos_ch_o),
    .neg_ch_o      (neg_ch_o),
    .neg_gnd_o     (neg_gnd_o)
  );

  assign state_o  = state_q;
  assign sdo_oe_o = in_frame;
  assign sdo_o    = (state_q == ST_XFER) && shift_bit;

  // R2: strobe high for two synchronized cycles means the driver is off
  p_hiz_conv_high_r2 : assert property (@(posedge clk_i) disable iff (!rst_n)
    (conv_lvl && $past(conv_lvl)) |-> !sdo_oe_o);

  // R1: a conversion runs to its last count without leaving early
  p_conv_length_r1 : assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state_q == ST_CONV) && (conv_cnt_q != CONV_LAST)) |=> (state_q == ST_CONV));

  // R1: a conversion is only entered after a strobe rise
  p_conv_from_rise_r1 : assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(state_q == ST_CONV) |-> $past(conv_rise));

  // R5: trailing phase drives zeros with the driver on
  p_tail_zero_r5 : assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> (sdo_oe_o && !sdo_o));

endmodule

// File: tb/adc_port_emu_test.sv
module adc_port_emu_test;

  localparam int DW    = 12;
  localparam int NCONV = 40;
  localparam int HOLD  = 8;
  localparam int NVEC  = 6;

  // each entry: {sample[11:0], sgl, odd}
  localparam logic [13:0] VEC [NVEC] = '{
    {12'hA5C, 1'b0, 1'b1},
    {12'h000, 1'b0, 1'b0},
    {12'hFFF, 1'b1, 1'b1},
    {12'h801, 1'b1, 1'b0},
    {12'h3C6, 1'b0, 1'b1},
    {12'h5A3, 1'b1, 1'b1}
  };

  logic          clk, rst_n, conv, sck, sdi;
  logic [DW-1:0] sample;
  logic          sdo, oe, pos, negc, gnd;
  logic [2:0]    st;

  int checks = 0;
  int errors = 0;
  logic exp_pos = 1'b0;
  logic exp_gnd = 1'b1;
  logic exp_neg = 1'b0;

  adc_port_emu #(
    .DATA_W      (DW),
    .CONV_CYCLES (NCONV),
    .SYNC_STAGES (2)
  ) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .conv_i    (conv),
    .sck_i     (sck),
    .sdi_i     (sdi),
    .sample_i  (sample),
    .sdo_o     (sdo),
    .sdo_oe_o  (oe),
    .pos_ch_o  (pos),
    .neg_ch_o  (negc),
    .neg_gnd_o (gnd),
    .state_o   (st)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req);
    check({req, " pos"}, 32'(pos), 32'(exp_pos));
    check({req, " gnd"}, 32'(gnd), 32'(exp_gnd));
    check({req, " neg"}, 32'(negc), 32'(exp_neg));
  endtask

  task automatic sck_pulse(input logic d);
    sdi = d;
    sck = 1'b1;
    wait_clk(HOLD);
    sck = 1'b0;
    wait_clk(HOLD);
  endtask

  task automatic frame(input logic [DW-1:0] smp, input logic s, input logic o);
    sample = smp;
    conv = 1'b1;
    wait_clk(NCONV + 8);
    check("R2 sleep state", 32'(st), 32'd2);
    check("R2 driver off", 32'(oe), 32'd0);
    check_pair("R8 R7 pair at start");
    sample = ~smp;
    wait_clk(2);
    conv = 1'b0;
    wait_clk(6);
    check("R3 transfer state", 32'(st), 32'd3);
    check("R3 driver on", 32'(oe), 32'd1);
    check("R3 first bit", 32'(sdo), 32'(smp[DW-1]));
    for (int k = 1; k <= DW; k++) begin
      logic d;
      d = (k == 1) ? s : (k == 2) ? o : (1'(k) ^ s);
      sck_pulse(d);
      if (k < DW) check("R4 R11 bit", 32'(sdo), 32'(smp[DW-1-k]));
      else        check("R5 zero after word", 32'(sdo), 32'd0);
    end
    for (int k = 0; k < 3; k++) begin
      sck_pulse(1'(k));
      check("R5 trailing zero", 32'(sdo), 32'd0);
      check("R5 trailing state", 32'(st), 32'd4);
    end
    exp_pos = o;
    exp_gnd = s;
    exp_neg = s ? 1'b0 : ~o;
  endtask

  initial begin
    rst_n  = 1'b0;
    conv   = 1'b0;
    sck    = 1'b0;
    sdi    = 1'b0;
    sample = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);

    // R10: reset state
    check("R10 state", 32'(st), 32'd0);
    check("R10 driver", 32'(oe), 32'd0);
    check("R10 sdo", 32'(sdo), 32'd0);
    check_pair("R10 pair");

    // table of frames
    for (int v = 0; v < NVEC; v++) begin
      frame(VEC[v][13:2], VEC[v][1], VEC[v][0]);
    end

    // R1: conversion length with the strobe held high
    begin
      int n;
      n = 0;
      conv = 1'b1;
      for (int i = 0; i < NCONV + 20; i++) begin
        @(negedge clk);
        if (st == 3'd1) n++;
      end
      check("R1 conversion length", 32'(n), 32'(NCONV));
      check("R1 ends in sleep", 32'(st), 32'd2);
      check_pair("R8 pair after last table word");
    end

    // R9: abort during transfer
    conv = 1'b0;
    wait_clk(6);
    for (int k = 0; k < 4; k++) sck_pulse(1'b1);
    check("R9 still transferring", 32'(st), 32'd3);
    conv = 1'b1;
    wait_clk(5);
    check("R9 abort restarts conversion", 32'(st), 32'd1);
    check("R9 R2 driver off after abort", 32'(oe), 32'd0);
    wait_clk(NCONV + 8);

    // R6: partial word leaves stored word unchanged
    conv = 1'b0;
    wait_clk(6);
    sck_pulse(~exp_gnd);
    conv = 1'b1;
    wait_clk(NCONV + 8);
    check_pair("R6 partial word ignored");

    // R9 / R3: rise during conversion ignored, end with strobe low
    conv = 1'b0;
    wait_clk(6);
    sample = 12'hA35;
    conv = 1'b1;
    wait_clk(4);
    conv = 1'b0;
    wait_clk(4);
    conv = 1'b1;
    wait_clk(4);
    conv = 1'b0;
    wait_clk(NCONV + 4 - 12);
    check("R9 second rise ignored", 32'(st), 32'd3);
    check("R3 direct transfer driver", 32'(oe), 32'd1);
    check("R3 direct transfer bit11", 32'(sdo), 32'd1);
    sck_pulse(1'b0);
    check("R4 direct transfer bit10", 32'(sdo), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule